// File: doc/BRIEF.md
# Clock Domain Sleep/Wake Controller

This block decides whether the clock of a single clock domain runs or is gated. Software picks one of four policies through a 2-bit mode field:
- **Keep awake:** the domain may wake but must never start sleeping.
- **Force sleep:** the domain is driven into sleep.
- **Force wake:** the domain is driven awake.
- **Automatic:** the block gates the clock when every module in the domain reports idle and no wakeup is pending, and ungates it when a wakeup request arrives.

The domain walks through four states: awake, sleep pending, gated and wake pending. Each of the two pending states lasts a programmable number of cycles.

The block drives a clock-gate enable and a clock-activity flag. The activity flag reads 0 only when the clock is certainly stopped. It stays 1 during both the gating and the ungating transitions.

Software reaches the block through a plain register port with a single-cycle write strobe and a combinational read. That port has no handshake and no back-pressure: every write is taken in the cycle its strobe is high, and read data follows the address within the same cycle. The idle and wakeup inputs are level signals, sampled at every clock edge.

Top module: `clkdom_ctrl`

## Requirements
- R1: After reset the mode field reads 3 (automatic), the domain is gated (state code 2), `clk_active` is 0 and `clk_gate_en` is 0.
- R2: Address 0 is the control register: bits [1:0] hold the mode (0 keep awake, 1 force sleep, 2 force wake, 3 automatic) and bits [3:2] read 0. A write becomes visible to the state machine one clock after the write edge. Address 1 is the read-only status register, and writes to it change nothing.
- R3: In keep-awake mode an awake domain never enters sleep pending, even with all modules idle. A gated domain in this mode stays gated until `wake_req` is 1, then enters wake pending.
- R4: In force-sleep mode an awake domain enters sleep pending on the next edge whatever the inputs are. A gated domain in this mode ignores `wake_req`.
- R5: In force-wake mode a gated domain enters wake pending without any `wake_req`. An awake domain in this mode stays awake even with all modules idle.
- R6: In automatic mode an awake domain enters sleep pending when `all_idle` is 1 and `wake_req` is 0. A gated domain enters wake pending when `wake_req` is 1.
- R7: Sleep pending and wake pending each last exactly TRANS_CYCLES cycles (default 4), unless sleep pending is aborted.
- R8: In sleep pending, the domain returns to awake on the next edge, without being gated, in either case:
  - `wake_req` is 1 and the mode is not force sleep; or
  - the mode becomes keep awake or force wake.
- R9: `clk_active` is 0 only while the domain is gated, and 1 in the awake, sleep pending and wake pending states.
- R10: `clk_gate_en` is 1 in the awake and sleep pending states, and 0 in the gated and wake pending states.
- R11: The state codes are: awake 0, sleep pending 1, gated 2, wake pending 3. `dom_state` and status bits [3:2] carry the state code, status bit 1 is `clk_gate_en` and status bit 0 is `clk_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (free running, never gated) |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address: 0 control, 1 status |
| reg_wdata | input | 2 | Write data (mode field) |
| reg_rdata | output | 4 | Combinational read data for `reg_addr` |
| all_idle | input | 1 | All modules of the domain report idle |
| wake_req | input | 1 | Wakeup request towards the domain |
| clk_gate_en | output | 1 | Enable for the domain clock gate |
| clk_active | output | 1 | Clock activity flag: 0 only when definitely gated |
| dom_state | output | 2 | Current domain state code |

## Verification
The hardest situation to reach is a sleep that is aborted partway through the sleep-pending window. The domain has to be driven awake, then into sleep pending, and then interrupted inside its fixed dwell time, either by a wakeup pulse or by a mode write. The write must land early enough that its one-cycle latency still falls before the timer ends.

The directed tasks get there by pulsing `all_idle` for a single cycle in automatic mode. They then raise `wake_req`, or issue the write to keep awake, one cycle into the window. They check that the state is still sleep pending right after the write, and that it is awake on the following cycle, with the gate enable never having dropped.

// File: rtl/clkdom_pkg.sv
package clkdom_pkg;

  localparam int unsigned MODE_W = 2;
  localparam int unsigned RD_W   = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_KEEP   = 2'd0,
    MODE_FSLEEP = 2'd1,
    MODE_FWAKE  = 2'd2,
    MODE_AUTO   = 2'd3
  } tmode_e;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_SLP_PD = 2'd1,
    ST_GATED  = 2'd2,
    ST_WAK_PD = 2'd3
  } dstate_e;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  // Whether an awake domain may begin its sleep transition.
  function automatic logic may_sleep(tmode_e m, logic idle, logic wk);
    unique case (m)
      MODE_FSLEEP: may_sleep = 1'b1;
      MODE_AUTO:   may_sleep = idle & ~wk;
      default:     may_sleep = 1'b0;
    endcase
  endfunction

  // Whether a gated domain should begin its wake transition.
  function automatic logic may_wake(tmode_e m, logic wk);
    unique case (m)
      MODE_FWAKE:  may_wake = 1'b1;
      MODE_FSLEEP: may_wake = 1'b0;
      default:     may_wake = wk;
    endcase
  endfunction

  // Whether an in-progress sleep must be abandoned.
  function automatic logic must_abort(tmode_e m, logic wk);
    unique case (m)
      MODE_KEEP, MODE_FWAKE: must_abort = 1'b1;
      MODE_AUTO:             must_abort = wk;
      default:               must_abort = 1'b0;
    endcase
  endfunction

  function automatic logic gate_open(dstate_e s);
    return (s == ST_ACTIVE) || (s == ST_SLP_PD);
  endfunction

  function automatic logic clk_busy(dstate_e s);
    return s != ST_GATED;
  endfunction

endpackage

// File: rtl/clkdom_regs.sv
module clkdom_regs
  import clkdom_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              addr,
  input  logic [MODE_W-1:0] wdata,
  input  dstate_e           state,
  input  logic              gate_en,
  input  logic              active,
  output tmode_e            mode,
  output logic [RD_W-1:0]   rdata
);

  tmode_e mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_AUTO;
    end else if (wr && (addr == ADDR_CTRL)) begin
      mode_q <= tmode_e'(wdata);
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_CTRL) begin
      rdata[MODE_W-1:0] = mode_q;
    end else begin
      rdata[3:2] = state;
      rdata[1]   = gate_en;
      rdata[0]   = active;
    end
  end

  assign mode = mode_q;

endmodule

// File: rtl/clkdom_timer.sv
module clkdom_timer #(
  parameter int unsigned TRANS_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic done
);

  generate
    if (TRANS_CYCLES <= 1) begin : g_none
      logic unused_in;
      assign unused_in = clk ^ rst_n ^ load ^ run;
      assign done = 1'b1 | unused_in;
    end else begin : g_cnt
      localparam int unsigned CW = $clog2(TRANS_CYCLES);
      localparam logic [CW-1:0] LAST = CW'(TRANS_CYCLES - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (load) begin
          cnt_q <= LAST;
        end else if (run && (cnt_q != '0)) begin
          cnt_q <= cnt_q - 1'b1;
        end
      end

      assign done = (cnt_q == '0);
    end
  endgenerate

endmodule

// File: rtl/clkdom_fsm.sv
module clkdom_fsm
  import clkdom_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  tmode_e  mode,
  input  logic    all_idle,
  input  logic    wake_req,
  input  logic    tmr_done,
  output logic    tmr_load,
  output logic    tmr_run,
  output dstate_e state,
  output logic    gate_en,
  output logic    active
);

  dstate_e st_q, st_d;
  logic    gate_q, act_q;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    unique case (st_q)
      ST_ACTIVE: begin
        if (may_sleep(mode, all_idle, wake_req)) begin
          st_d     = ST_SLP_PD;
          tmr_load = 1'b1;
        end
      end
      ST_SLP_PD: begin
        if (must_abort(mode, wake_req)) begin
          st_d = ST_ACTIVE;
        end else if (tmr_done) begin
          st_d = ST_GATED;
        end
      end
      ST_GATED: begin
        if (may_wake(mode, wake_req)) begin
          st_d     = ST_WAK_PD;
          tmr_load = 1'b1;
        end
      end
      ST_WAK_PD: begin
        if (tmr_done) begin
          st_d = ST_ACTIVE;
        end
      end
      default: st_d = ST_GATED;
    endcase
  end

  assign tmr_run = (st_q == ST_SLP_PD) || (st_q == ST_WAK_PD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_GATED;
      gate_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      gate_q <= gate_open(st_d);
      act_q  <= clk_busy(st_d);
    end
  end

  assign state   = st_q;
  assign gate_en = gate_q;
  assign active  = act_q;

endmodule

// File: rtl/clkdom_ctrl.sv
module clkdom_ctrl
  import clkdom_pkg::*;
#(
  parameter int unsigned TRANS_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [MODE_W-1:0] reg_wdata,
  output logic [RD_W-1:0]  reg_rdata,
  input  logic             all_idle,
  input  logic             wake_req,
  output logic             clk_gate_en,
  output logic             clk_active,
  output logic [1:0]       dom_state
);

  tmode_e  mode_q;
  dstate_e st;
  logic    t_load, t_run, t_done;
  logic    gate_w, act_w;

  clkdom_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .state   (st),
    .gate_en (gate_w),
    .active  (act_w),
    .mode    (mode_q),
    .rdata   (reg_rdata)
  );

  clkdom_timer #(.TRANS_CYCLES(TRANS_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (t_load),
    .run   (t_run),
    .done  (t_done)
  );

  clkdom_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_q),
    .all_idle (all_idle),
    .wake_req (wake_req),
    .tmr_done (t_done),
    .tmr_load (t_load),
    .tmr_run  (t_run),
    .state    (st),
    .gate_en  (gate_w),
    .active   (act_w)
  );

  assign clk_gate_en = gate_w;
  assign clk_active  = act_w;
  assign dom_state   = st;

endmodule

// File: rtl/clkdom_ctrl_chk.sv
module clkdom_ctrl_chk
  import clkdom_pkg::*;
#(
  parameter int unsigned TRANS_CYCLES = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic       reg_addr,
  input logic [1:0] mode,
  input logic       all_idle,
  input logic       wake_req,
  input logic       clk_gate_en,
  input logic       clk_active,
  input logic [1:0] dom_state
);

  localparam int unsigned AW = $clog2(TRANS_CYCLES + 1) + 1;
  localparam logic [AW-1:0] LAST = AW'(TRANS_CYCLES - 1);

  logic [1:0]    prev_q;
  logic [AW-1:0] age_q, age;
  logic          pend;

  assign pend = (dom_state == ST_SLP_PD) || (dom_state == ST_WAK_PD);
  assign age  = (dom_state == prev_q) ? ((age_q == '1) ? age_q : age_q + 1'b1) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= ST_GATED;
      age_q  <= '0;
    end else begin
      prev_q <= dom_state;
      age_q  <= age;
    end
  end

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == ADDR_CTRL) |=> $stable(mode)); // R2
  AST_KEEP_NO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_state == ST_ACTIVE && mode == MODE_KEEP) |=> dom_state == ST_ACTIVE); // R3
  AST_FSLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_state == ST_GATED && mode == MODE_FSLEEP) |=> dom_state == ST_GATED); // R4
  AST_AUTO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_state == ST_ACTIVE && mode == MODE_AUTO && all_idle && !wake_req)
      |=> dom_state == ST_SLP_PD); // R6
  AST_DWELL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> age <= LAST); // R7
  AST_DWELL_END: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && age == LAST) |=> dom_state != $past(dom_state)); // R7
  AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_state == ST_SLP_PD && mode == MODE_AUTO && wake_req) |=> dom_state == ST_ACTIVE); // R8
  AST_GATED_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_state == ST_GATED) |=> (dom_state == ST_GATED || dom_state == ST_WAK_PD)); // R5
  AST_ACT_COVERS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    clk_gate_en |-> clk_active); // R9
  AST_WAKE_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_state == ST_WAK_PD) |-> (clk_active && !clk_gate_en)); // R10

endmodule

bind clkdom_ctrl clkdom_ctrl_chk #(.TRANS_CYCLES(TRANS_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .mode        (mode_q),
  .all_idle    (all_idle),
  .wake_req    (wake_req),
  .clk_gate_en (clk_gate_en),
  .clk_active  (clk_active),
  .dom_state   (dom_state)
);

// File: tb/test_clkdom_ctrl.sv
module test_clkdom_ctrl;

  localparam int TC = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [1:0] reg_wdata = 2'd0;
  logic [3:0] reg_rdata;
  logic       all_idle = 1'b0;
  logic       wake_req = 1'b0;
  logic       clk_gate_en, clk_active;
  logic [1:0] dom_state;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  clkdom_ctrl #(.TRANS_CYCLES(TC)) i_clkdom_ctrl (
    .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .all_idle (all_idle),
    .wake_req (wake_req), .clk_gate_en (clk_gate_en), .clk_active (clk_active),
    .dom_state (dom_state)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mode(input logic [1:0] m);
    reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = m;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic chk_out(input string req, input int st, input int act, input int gate);
    chk({req, " state"}, dom_state, st);
    chk({req, " clk_active"}, clk_active, act);
    chk({req, " clk_gate_en"}, clk_gate_en, gate);
  endtask

  // Brings the domain from gated to awake via automatic wakeup.
  task automatic go_active();
    wake_req = 1'b1; step(1); wake_req = 1'b0;
    step(TC);
  endtask

  task automatic go_gated_fsleep();
    wr_mode(2'd1);
    step(TC + 1);
  endtask

  task automatic t_reset();
    reg_addr = 1'b0;
    #1;
    chk("R1 mode", reg_rdata, 3);
    chk_out("R1", 2, 0, 0);
    reg_addr = 1'b1;
    #1;
    chk("R11 status gated", reg_rdata, 4'b1000);
    reg_addr = 1'b0;
  endtask

  task automatic t_auto_cycle();
    wake_req = 1'b1; step(1); wake_req = 1'b0;
    chk_out("R6 wake start", 3, 1, 0);
    reg_addr = 1'b1; #1;
    chk("R11 status wake", reg_rdata, 4'b1101);
    reg_addr = 1'b0;
    step(TC - 1);
    chk("R7 wake dwell", dom_state, 3);
    step(1);
    chk_out("R10 awake", 0, 1, 1);
    all_idle = 1'b1; step(1); all_idle = 1'b0;
    chk_out("R6 sleep start", 1, 1, 1);
    reg_addr = 1'b1; #1;
    chk("R11 status sleep", reg_rdata, 4'b0111);
    reg_addr = 1'b0;
    step(TC - 1);
    chk("R7 sleep dwell", dom_state, 1);
    step(1);
    chk_out("R9 gated", 2, 0, 0);
  endtask

  task automatic t_abort();
    go_active();
    all_idle = 1'b1; step(1); all_idle = 1'b0;
    step(1);
    chk("R8 pending", dom_state, 1);
    wake_req = 1'b1; step(1); wake_req = 1'b0;
    chk_out("R8 abort wake", 0, 1, 1);
    all_idle = 1'b1; step(1); all_idle = 1'b0;
    chk("R8 pending again", dom_state, 1);
    wr_mode(2'd0);
    chk("R2 write latency", dom_state, 1);
    step(1);
    chk_out("R8 abort mode", 0, 1, 1);
  endtask

  task automatic t_keep();
    all_idle = 1'b1;
    step(3 * TC);
    chk("R3 no sleep", dom_state, 0);
    all_idle = 1'b0;
    go_gated_fsleep();
    chk("R4 forced gated", dom_state, 2);
    wake_req = 1'b1; step(3);
    chk("R4 wake ignored", dom_state, 2);
    wr_mode(2'd0);
    step(1);
    chk("R3 waking", dom_state, 3);
    wake_req = 1'b0;
    step(TC);
    chk("R3 awake", dom_state, 0);
  endtask

  task automatic t_fsleep_from_active();
    wake_req = 1'b1;
    wr_mode(2'd1);
    chk("R2 latency", dom_state, 0);
    step(1);
    chk("R4 forced sleep", dom_state, 1);
    step(TC);
    chk_out("R4 gated despite wake", 2, 0, 0);
    wake_req = 1'b0;
  endtask

  task automatic t_fwake();
    wr_mode(2'd2);
    chk("R5 latency", dom_state, 2);
    step(1);
    chk_out("R5 wake start", 3, 1, 0);
    step(TC);
    chk("R5 awake", dom_state, 0);
    all_idle = 1'b1; step(2 * TC); all_idle = 1'b0;
    chk("R5 stays awake", dom_state, 0);
  endtask

  task automatic t_regs();
    reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 2'd1;
    step(1);
    reg_wr = 1'b0;
    reg_addr = 1'b0; #1;
    chk("R2 status write ignored", reg_rdata, 2);
    reg_addr = 1'b1; #1;
    chk("R11 status awake", reg_rdata, 4'b0011);
    step(2);
    chk("R2 state kept", dom_state, 0);
    wr_mode(2'd3);
    reg_addr = 1'b0; #1;
    chk("R2 mode auto", reg_rdata, 3);
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_auto_cycle();
    t_abort();
    t_keep();
    t_fsleep_from_active();
    t_fwake();
    t_regs();
    step(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule